// File: doc/BRIEF.md
# Scaled FP8-to-BF16 vector widening converter

This block widens a vector of packed 8-bit floating-point elements into BFloat16 elements and divides every converted value by a programmable power of two on the way. Two independent control sets, each made of a 6-bit unsigned scale and a one-bit FP8 format selector, come with every operation, and a set-select input chooses which of them is applied. The conversion is unpredicated: every element is converted on every operation.

The doubled-width result is split in element order across two destination vectors. The low-numbered half of the elements goes to the first vector and the high-numbered half goes to the second. Operations enter through a valid/ready input carrying the source vector, both control sets and the select bit. The result leaves through a registered valid/ready output with one cycle of latency, and it is held until the consumer takes it.

Every FP8 mantissa fits inside the BF16 fraction, and any FP8 value scaled down by up to 2^63 stays inside the BF16 normal range. Each finite result is therefore exact, and the block has no rounding logic.

Top module: `fp8_bf16_widen`

## Requirements
- R1: With NE = VLEN/8, source element e at `src_vec[8e+7:8e]` produces a 16-bit result. For e < NE/2 the result is at `dst_lo[16e+15:16e]`. Otherwise it is at `dst_hi[16(e-NE/2)+15:16(e-NE/2)]`.
- R2: When `set_sel` is 0, `scale_a` and `fmt_a` are applied. When it is 1, `scale_b` and `fmt_b` are applied. The set that is not selected has no effect on the result.
- R3: Format 0 is E5M2: sign in bit 7, a 5-bit exponent in bits [6:2] with bias 15, and a 2-bit mantissa in bits [1:0]. Normal inputs at scale 0 convert exactly. Bits [3:0] of every result other than a NaN are zero.
- R4: Format 1 is E4M3: sign in bit 7, a 4-bit exponent in bits [6:3] with bias 7, and a 3-bit mantissa in bits [2:0]. Normal inputs at scale 0 convert exactly.
- R5: Subnormal inputs (exponent field 0, mantissa not 0) are normalised exactly. In E5M2 they are worth mantissa·2^-16, and in E4M3 they are worth mantissa·2^-9.
- R6: A finite nonzero input with scale S yields its value times 2^-S for S in 0..63. The result is always a BF16 normal number, so its exponent field is never 0.
- R7: A zero input yields a zero of the same sign (0x0000 or 0x8000) at any scale.
- R8: An E5M2 input with exponent 31 and mantissa 0 yields signed infinity (0x7F80 or 0xFF80) at any scale. An E5M2 input with exponent 31 and mantissa not 0 yields 0x7FC0. So does an E4M3 input with all seven low bits set, whatever its sign.
- R9: An E4M3 input with exponent 15 and a mantissa below 7 is finite. For example, 0x7E (448) yields 0x43E0 at scale 0.
- R10: `src_ready` equals `!dst_valid || dst_ready`. An accepted operation shows `dst_valid` and its result after the next clock edge. While `dst_valid` is high and `dst_ready` is low, the outputs stay unchanged.
- R11: While reset is held and after reset is released, `dst_valid` is 0 and `src_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Operation offered |
| src_ready | output | 1 | Operation can be taken this cycle |
| src_vec | input | VLEN | Packed FP8 source elements |
| set_sel | input | 1 | Control set select (0: set A, 1: set B) |
| scale_a | input | 6 | Downscale exponent of set A |
| fmt_a | input | 1 | FP8 format of set A (0 E5M2, 1 E4M3) |
| scale_b | input | 6 | Downscale exponent of set B |
| fmt_b | input | 1 | FP8 format of set B (0 E5M2, 1 E4M3) |
| dst_valid | output | 1 | Result held on the destination vectors |
| dst_ready | input | 1 | Consumer takes the result |
| dst_lo | output | VLEN | First destination vector (lower elements) |
| dst_hi | output | VLEN | Second destination vector (upper elements) |

## Verification
Two functions can fall in the same clock edge: the consumer taking the held result, and a new operation being accepted into the same output register. The bench provokes this by stalling the output with a result held and a second operation waiting, then raising the ready input. It judges the outcome by checking that the first result stayed unchanged during the stall, that the input became ready in the same cycle the ready input rose, and that exactly the second operation's expected result is present after that edge. The expected results come from a bench model that builds each element's real value and reads the BF16 fields from its double-precision bits.

// File: rtl/fp8_bf16_widen.sv
module fp8_bf16_widen #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_valid,
  output logic            src_ready,
  input  logic [VLEN-1:0] src_vec,
  input  logic            set_sel,
  input  logic [5:0]      scale_a,
  input  logic            fmt_a,
  input  logic [5:0]      scale_b,
  input  logic            fmt_b,
  output logic            dst_valid,
  input  logic            dst_ready,
  output logic [VLEN-1:0] dst_lo,
  output logic [VLEN-1:0] dst_hi
);
  localparam int NE = VLEN / 8;

  function automatic logic [15:0] widen(input logic [7:0] b, input logic f, input logic [5:0] s);
    logic       sg, nan, inf, zero;
    logic [4:0] ex;
    logic [2:0] mt, fr;
    logic [8:0] base, be;
    sg = b[7];
    ex = f ? {1'b0, b[6:3]} : b[6:2];
    mt = f ? b[2:0] : {b[1:0], 1'b0};
    base = f ? 9'd120 : 9'd112;
    nan  = f ? (b[6:0] == 7'h7F) : (ex == 5'd31 && b[1:0] != 2'b00);
    inf  = !f && ex == 5'd31 && b[1:0] == 2'b00;
    zero = ex == 5'd0 && mt == 3'd0;
    if (ex != 5'd0) begin
      be = {4'd0, ex} + base - {3'd0, s};
      fr = mt;
    end else if (mt[2]) begin
      be = base - {3'd0, s};
      fr = {mt[1:0], 1'b0};
    end else if (mt[1]) begin
      be = base - 9'd1 - {3'd0, s};
      fr = {mt[0], 2'b00};
    end else begin
      be = base - 9'd2 - {3'd0, s};
      fr = 3'd0;
    end
    if (nan)       widen = 16'h7FC0;
    else if (inf)  widen = {sg, 8'hFF, 7'd0};
    else if (zero) widen = {sg, 15'd0};
    else           widen = {sg, be[7:0], fr, 4'd0};
  endfunction

  logic            use_fmt;
  logic [5:0]      use_scale;
  logic [2*VLEN-1:0] conv, res;
  logic            take;

  assign use_fmt   = set_sel ? fmt_b : fmt_a;
  assign use_scale = set_sel ? scale_b : scale_a;
  assign src_ready = !dst_valid || dst_ready;
  assign take      = src_valid && src_ready;
  assign dst_lo    = res[VLEN-1:0];
  assign dst_hi    = res[2*VLEN-1:VLEN];

  for (genvar e = 0; e < NE; e++) begin : g_elem
    assign conv[16*e +: 16] = widen(src_vec[8*e +: 8], use_fmt, use_scale);

    assert_normal_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid |-> !(res[16*e+7 +: 8] == 8'd0 && res[16*e +: 7] != 7'd0));
    assert_exact_frac_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && res[16*e +: 16] != 16'h7FC0) |-> res[16*e +: 4] == 4'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_valid <= 1'b0;
      res       <= '0;
    end else if (take) begin
      dst_valid <= 1'b1;
      res       <= conv;
    end else if (dst_ready) begin
      dst_valid <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(res)));
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> dst_valid);
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |-> !src_ready);
  assert_idle_R11: assert property (@(posedge clk)
    $fell(rst_n) |=> !dst_valid);
endmodule

// File: tb/fp8_bf16_widen_tb.sv
module fp8_bf16_widen_tb;
  localparam int VLEN = 128;
  localparam int NE = VLEN / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_valid = 1'b0, set_sel = 1'b0, fmt_a = 1'b0, fmt_b = 1'b0, dst_ready = 1'b1;
  logic [5:0] scale_a = '0, scale_b = '0;
  logic [VLEN-1:0] src_vec = '0;
  logic src_ready, dst_valid;
  logic [VLEN-1:0] dst_lo, dst_hi;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  fp8_bf16_widen #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_vec(src_vec), .set_sel(set_sel), .scale_a(scale_a), .fmt_a(fmt_a),
    .scale_b(scale_b), .fmt_b(fmt_b), .dst_valid(dst_valid), .dst_ready(dst_ready),
    .dst_lo(dst_lo), .dst_hi(dst_hi));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles exp under 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic real pow2(input int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else        for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic logic [15:0] ref_elem(input logic [7:0] b, input logic f, input int s);
    int ex, m;
    real v;
    logic [63:0] d;
    logic [10:0] de;
    logic sg = b[7];
    if (!f) begin
      ex = int'(b[6:2]); m = int'(b[1:0]);
      if (ex == 31) return (m == 0) ? {sg, 8'hFF, 7'h00} : 16'h7FC0;
      v = (ex == 0) ? m * pow2(-16) : (4 + m) * pow2(ex - 17);
    end else begin
      ex = int'(b[6:3]); m = int'(b[2:0]);
      if (ex == 15 && m == 7) return 16'h7FC0;
      v = (ex == 0) ? m * pow2(-9) : (8 + m) * pow2(ex - 10);
    end
    if (ex == 0 && m == 0) return {sg, 15'd0};
    v = v * pow2(-s);
    d = $realtobits(v);
    de = d[62:52] - 11'd896;
    return {sg, de[7:0], d[51:45]};
  endfunction

  function automatic logic [2*VLEN-1:0] ref_vec(input logic [VLEN-1:0] v, input logic f, input int s);
    logic [2*VLEN-1:0] r;
    for (int e = 0; e < NE; e++) r[16*e +: 16] = ref_elem(v[8*e +: 8], f, s);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [VLEN-1:0] got, input logic [VLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [VLEN-1:0] v, input logic sel, input logic [5:0] sa,
                       input logic fa, input logic [5:0] sb, input logic fb);
    src_vec = v; set_sel = sel; scale_a = sa; fmt_a = fa; scale_b = sb; fmt_b = fb;
    src_valid = 1'b1;
  endtask

  task automatic run_op(input string tag, input logic [VLEN-1:0] v, input logic sel,
                        input logic [5:0] sa, input logic fa, input logic [5:0] sb, input logic fb);
    logic [2*VLEN-1:0] e;
    e = sel ? ref_vec(v, fb, int'(sb)) : ref_vec(v, fa, int'(sa));
    @(negedge clk);
    drive(v, sel, sa, fa, sb, fb);
    @(negedge clk);
    src_valid = 1'b0;
    checks++;
    if (dst_valid !== 1'b1) begin
      errors++;
      $display("FAIL R10 valid after accept: got %b exp 1", dst_valid);
    end
    chk(tag, dst_lo, e[VLEN-1:0]);
    chk(tag, dst_hi, e[2*VLEN-1:VLEN]);
  endtask

  function automatic logic [VLEN-1:0] codes(input int base);
    logic [VLEN-1:0] v;
    for (int e = 0; e < NE; e++) v[8*e +: 8] = 8'(base + e);
    return v;
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int e = 0; e < NE; e++) v[8*e +: 8] = 8'($urandom);
    return v;
  endfunction

  initial begin
    logic [2*VLEN-1:0] ea, eb;
    logic [VLEN-1:0] va, vb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checks++;
    if (dst_valid !== 1'b0 || src_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 in reset: got valid %b ready %b exp 0 1", dst_valid, src_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dst_valid !== 1'b0 || src_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 after reset: got valid %b ready %b exp 0 1", dst_valid, src_ready);
    end

    // all 256 codes, both formats, scale 0 and 63 and mid (R1 R3 R4 R5 R6 R7 R8 R9)
    for (int c = 0; c < 256; c += NE) begin
      run_op("R1 R3 R5 R7 R8 E5M2 scale0", codes(c), 1'b0, 6'd0, 1'b0, 6'd0, 1'b0);
      run_op("R1 R4 R5 R7 R8 R9 E4M3 scale0", codes(c), 1'b0, 6'd0, 1'b1, 6'd0, 1'b0);
      run_op("R6 R7 R8 E5M2 scale63", codes(c), 1'b0, 6'd63, 1'b0, 6'd0, 1'b0);
      run_op("R6 R7 R8 E4M3 scale63 via set B R2", codes(c), 1'b1, 6'd0, 1'b0, 6'd63, 1'b1);
      run_op("R6 E4M3 scale 21", codes(c), 1'b0, 6'd21, 1'b1, 6'd5, 1'b0);
    end

    // R9 directed: 448 in E4M3 at scale 0 in element 0
    va = '0; va[7:0] = 8'h7E;
    run_op("R9 max E4M3", va, 1'b0, 6'd0, 1'b1, 6'd0, 1'b0);
    checks++;
    if (dst_lo[15:0] !== 16'h43E0) begin
      errors++;
      $display("FAIL R9 448: got %h exp 43e0", dst_lo[15:0]);
    end

    // R2: unused set ignored
    va = rnd_vec();
    for (int k = 0; k < 6; k++) begin
      run_op("R2 set A with random set B", va, 1'b0, 6'd9, 1'b1, 6'($urandom), 1'($urandom));
      run_op("R2 set B with random set A", va, 1'b1, 6'($urandom), 1'($urandom), 6'd17, 1'b0);
    end

    // random mix (R1 R2 R6)
    for (int k = 0; k < 200; k++)
      run_op("R1 R2 R6 random", rnd_vec(), 1'($urandom), 6'($urandom), 1'($urandom),
             6'($urandom), 1'($urandom));

    // R10: stall with second op waiting, then release
    va = rnd_vec(); vb = rnd_vec();
    ea = ref_vec(va, 1'b1, 3);
    eb = ref_vec(vb, 1'b0, 40);
    @(negedge clk);
    dst_ready = 1'b0;
    drive(va, 1'b0, 6'd3, 1'b1, 6'd0, 1'b0);
    @(negedge clk);
    drive(vb, 1'b1, 6'd0, 1'b1, 6'd40, 1'b0);
    repeat (3) @(negedge clk);
    checks++;
    if (src_ready !== 1'b0 || dst_valid !== 1'b1) begin
      errors++;
      $display("FAIL R10 stall: got ready %b valid %b exp 0 1", src_ready, dst_valid);
    end
    chk("R10 held lo", dst_lo, ea[VLEN-1:0]);
    chk("R10 held hi", dst_hi, ea[2*VLEN-1:VLEN]);
    dst_ready = 1'b1;
    #1;
    checks++;
    if (src_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 ready follows dst_ready: got %b exp 1", src_ready);
    end
    @(negedge clk);
    src_valid = 1'b0;
    chk("R10 next lo", dst_lo, eb[VLEN-1:0]);
    chk("R10 next hi", dst_hi, eb[2*VLEN-1:VLEN]);
    @(negedge clk);
    checks++;
    if (dst_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 drained: got %b exp 0", dst_valid);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule